// File: doc/BRIEF.md
# Halfword Signed Multiply-Accumulate Unit

A single-cycle registered DSP multiply unit. Each accepted operation takes two 32-bit operands, a 32-bit accumulate operand, a 64-bit accumulate pair given as high and low words, two halfword-select bits, a no-accumulate bit and a 2-bit operation code. One cycle after `valid_i` it presents a registered 32-bit result, a registered 64-bit result pair and a sticky signed-overflow flag.

Four operations exist:
- a 16x16 signed multiply;
- the same multiply with a wrapping 32-bit accumulate;
- a 32x16 signed multiply that keeps the middle word of the 48-bit product, with an optional wrapping accumulate;
- a 16x16 multiply added into a 64-bit accumulator.

The 32-bit accumulates never saturate. They record signed overflow in a flag that only an explicit clear resets. Decode, register-file access and condition handling belong to the surrounding pipeline.

Top module: `hw_mac_unit`

## Requirements
- R1: A halfword-select bit of 1 picks bits [31:16] of its operand and 0 picks bits [15:0]. The picked halfword is treated as signed. `sel_a_i` applies to `a_i` and `sel_b_i` applies to `b_i`.
- R2: With `op_i` = 0, `res_o` is the 32-bit signed product of the two picked halfwords, and `ovf_o` is left unchanged.
- R3: With `op_i` = 1, `res_o` is the product of R2 plus `acc_i`, wrapped modulo 2^32.
- R4: With `op_i` = 1, signed overflow of that 32-bit addition sets `ovf_o`, and `res_o` still holds the wrapped sum.
- R5: With `op_i` = 2, the full signed `a_i` is multiplied by the signed halfword of `b_i` picked by `sel_b_i`, and bits [47:16] of the 48-bit product form the base result. `sel_a_i` has no effect.
- R6: With `op_i` = 2 and `no_acc_i` = 0, `res_o` is the base result plus `acc_i`, wrapped, and signed overflow sets `ovf_o`. With `no_acc_i` = 1, `res_o` is the base result and `ovf_o` is unchanged.
- R7: With `op_i` = 3, {`res_hi_o`,`res_lo_o`} becomes {`acc_hi_i`,`acc_lo_i`} plus the sign-extended halfword product, wrapped modulo 2^64. `res_o` equals the new low word, and `ovf_o` is unchanged.
- R8: `res_hi_o` and `res_lo_o` change only on an operation with `op_i` = 3. They hold their value otherwise.
- R9: `ovf_o` is sticky. `flag_clr_i` clears it on the next edge whether or not `valid_i` is high. An overflow in the same cycle as a clear leaves the flag set.
- R10: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high, and the results appear with it. Without `valid_i`, `res_o`, `res_hi_o` and `res_lo_o` hold their value.
- R11: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Start an operation this cycle |
| op_i | input | 2 | Operation code: 0 mul, 1 mac32, 2 word-by-half, 3 mac64 |
| sel_a_i | input | 1 | Halfword select for a_i (1 = upper) |
| sel_b_i | input | 1 | Halfword select for b_i (1 = upper) |
| no_acc_i | input | 1 | Word-by-half form: skip the accumulate |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| acc_i | input | 32 | 32-bit accumulate operand |
| acc_hi_i | input | 32 | Upper word of the 64-bit accumulate |
| acc_lo_i | input | 32 | Lower word of the 64-bit accumulate |
| flag_clr_i | input | 1 | Clear the sticky overflow flag |
| valid_o | output | 1 | Registered results valid |
| res_o | output | 32 | 32-bit result |
| res_hi_o | output | 32 | Upper word of the 64-bit result |
| res_lo_o | output | 32 | Lower word of the 64-bit result |
| ovf_o | output | 1 | Sticky signed-overflow flag |

## Verification
The assertions check the control behaviour on every cycle:
- the one-cycle `valid_o` timing;
- the hold of all results when no operation starts;
- the hold of the 64-bit pair across operations other than the mac64;
- the stickiness of the flag;
- that the flag rises only after an accumulating operation.

The arithmetic needs the bench's sweep. It covers every operation, both select bits and the no-accumulate bit, over signed halfword corners (0, 1, -1, 0x7fff, 0x8000 and mixed patterns). It uses accumulate values chosen to hit both overflow directions, and compares each result against values computed in 64-bit integer arithmetic. A clear asserted on the same cycle as an overflow, and idle cycles with changed inputs, are also only visible in those scenarios.

// File: rtl/hw_mac_pkg.sv
package hw_mac_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'd0,
    OP_MAC  = 2'd1,
    OP_MULW = 2'd2,
    OP_MACL = 2'd3
  } mac_op_e;
endpackage

// File: rtl/hw_half_pick.sv
module hw_half_pick #(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic              sel_i,
  output logic [DATA_W-1:0] half_x_o
);
  logic [HALF_W-1:0] half;
  assign half     = sel_i ? word_i[DATA_W-1:HALF_W] : word_i[HALF_W-1:0];
  assign half_x_o = {{HALF_W{half[HALF_W-1]}}, half};
endmodule

// File: rtl/hw_mac_core.sv
module hw_mac_core
  import hw_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int HALF_W = DATA_W / 2,
  localparam int PROD_W = DATA_W + HALF_W,
  localparam int LONG_W = 2 * DATA_W
) (
  input  mac_op_e           op_i,
  input  logic              sel_a_i,
  input  logic              sel_b_i,
  input  logic              no_acc_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [LONG_W-1:0] acc_long_i,
  output logic [DATA_W-1:0] res_o,
  output logic [LONG_W-1:0] res_long_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] ops   [2];
  logic              sels  [2];
  logic [DATA_W-1:0] halfx [2];

  assign ops[0]  = a_i;
  assign ops[1]  = b_i;
  assign sels[0] = sel_a_i;
  assign sels[1] = sel_b_i;

  for (genvar g = 0; g < 2; g++) begin : g_pick
    hw_half_pick #(.DATA_W(DATA_W)) u_pick (
      .word_i  (ops[g]),
      .sel_i   (sels[g]),
      .half_x_o(halfx[g])
    );
  end

  logic [DATA_W-1:0] prod_hh;
  logic [PROD_W-1:0] a_wide, b_wide, prod_wh;
  logic [DATA_W-1:0] mid_wh;
  logic [DATA_W-1:0] add_opd, add_sum;
  logic              add_ovf;

  assign prod_hh = halfx[0] * halfx[1];
  assign a_wide  = {{HALF_W{a_i[DATA_W-1]}}, a_i};
  assign b_wide  = {{HALF_W{halfx[1][DATA_W-1]}}, halfx[1]};
  assign prod_wh = a_wide * b_wide;
  assign mid_wh  = prod_wh[PROD_W-1:HALF_W];

  // shared 32-bit accumulate adder
  assign add_opd = (op_i == OP_MULW) ? mid_wh : prod_hh;
  assign add_sum = add_opd + acc_i;
  assign add_ovf = (add_opd[DATA_W-1] == acc_i[DATA_W-1]) &&
                   (add_sum[DATA_W-1] != acc_i[DATA_W-1]);

  assign res_long_o = acc_long_i + {{DATA_W{prod_hh[DATA_W-1]}}, prod_hh};

  always_comb begin
    res_o = prod_hh;
    ovf_o = 1'b0;
    unique case (op_i)
      OP_MUL:  res_o = prod_hh;
      OP_MAC: begin
        res_o = add_sum;
        ovf_o = add_ovf;
      end
      OP_MULW: begin
        res_o = no_acc_i ? mid_wh : add_sum;
        ovf_o = !no_acc_i && add_ovf;
      end
      OP_MACL: res_o = res_long_o[DATA_W-1:0];
      default: ;
    endcase
  end
endmodule

// File: rtl/hw_mac_unit.sv
module hw_mac_unit
  import hw_mac_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LONG_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic              sel_a_i,
  input  logic              sel_b_i,
  input  logic              no_acc_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] acc_hi_i,
  input  logic [DATA_W-1:0] acc_lo_i,
  input  logic              flag_clr_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o,
  output logic [DATA_W-1:0] res_hi_o,
  output logic [DATA_W-1:0] res_lo_o,
  output logic              ovf_o
);
  mac_op_e           op;
  logic [DATA_W-1:0] core_res;
  logic [LONG_W-1:0] core_long;
  logic              core_ovf;

  assign op = mac_op_e'(op_i);

  hw_mac_core #(.DATA_W(DATA_W)) u_core (
    .op_i      (op),
    .sel_a_i   (sel_a_i),
    .sel_b_i   (sel_b_i),
    .no_acc_i  (no_acc_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .acc_i     (acc_i),
    .acc_long_i({acc_hi_i, acc_lo_i}),
    .res_o     (core_res),
    .res_long_o(core_long),
    .ovf_o     (core_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      res_o    <= '0;
      res_hi_o <= '0;
      res_lo_o <= '0;
      ovf_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      // overflow in the clear cycle wins
      ovf_o   <= (ovf_o && !flag_clr_i) || (valid_i && core_ovf);
      if (valid_i) begin
        res_o <= core_res;
        if (op == OP_MACL) {res_hi_o, res_lo_o} <= core_long;
      end
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R10
  valid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o) && $stable(res_hi_o) && $stable(res_lo_o));
  // R8
  long_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i != 2'd3) |=> $stable(res_hi_o) && $stable(res_lo_o));
  // R9
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !flag_clr_i |=> ovf_o);
  // R2
  flag_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ovf_o && !(valid_i && (op_i == 2'd1 || (op_i == 2'd2 && !no_acc_i)))
      |=> !ovf_o);
endmodule

// File: tb/hw_mac_unit_bench.sv
module hw_mac_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0, sel_a = 1'b0, sel_b = 1'b0, no_acc = 1'b0, clr = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [31:0] a = '0, b = '0, acc = '0, acc_hi = '0, acc_lo = '0;
  logic        valid_o, ovf_o;
  logic [31:0] res_o, res_hi_o, res_lo_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_res = '0, exp_hi = '0, exp_lo = '0;
  logic        exp_ovf = 1'b0;

  always #10 clk = ~clk;

  hw_mac_unit u_hw_mac_unit (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op),
    .sel_a_i(sel_a), .sel_b_i(sel_b), .no_acc_i(no_acc),
    .a_i(a), .b_i(b), .acc_i(acc), .acc_hi_i(acc_hi), .acc_lo_i(acc_lo),
    .flag_clr_i(clr), .valid_o(valid_o), .res_o(res_o),
    .res_hi_o(res_hi_o), .res_lo_o(res_lo_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic longint sx16(input logic [15:0] h);
    return longint'(signed'(h));
  endfunction

  function automatic longint sx32(input logic [31:0] w);
    return longint'(signed'(w));
  endfunction

  function automatic bit ovf32(input longint s);
    return (s > 64'sd2147483647) || (s < -64'sd2147483648);
  endfunction

  // model of one operation from the requirements
  task automatic model;
    longint ha, hb, p, w, s;
    logic [63:0] l;
    bit f;
    ha = sx16(sel_a ? a[31:16] : a[15:0]);
    hb = sx16(sel_b ? b[31:16] : b[15:0]);
    p = ha * hb;
    f = 1'b0;
    case (op)
      2'd0: exp_res = p[31:0];
      2'd1: begin
        s = p + sx32(acc);
        exp_res = s[31:0];
        f = ovf32(s);
      end
      2'd2: begin
        w = (sx32(a) * hb) >>> 16;
        if (no_acc) exp_res = w[31:0];
        else begin
          s = w + sx32(acc);
          exp_res = s[31:0];
          f = ovf32(s);
        end
      end
      default: begin
        l = {acc_hi, acc_lo} + 64'(p);
        exp_hi = l[63:32];
        exp_lo = l[31:0];
        exp_res = l[31:0];
      end
    endcase
    exp_ovf = (exp_ovf && !clr) || f;
  endtask

  task automatic run_op;
    string tag;
    valid_i = 1'b1;
    model();
    case (op)
      2'd0: tag = "R1 R2";
      2'd1: tag = "R3 R4";
      2'd2: tag = "R5 R6";
      default: tag = "R7";
    endcase
    @(negedge clk);
    chk("R10 valid_o", 64'(valid_o), 64'd1);
    chk(tag, 64'(res_o), 64'(exp_res));
    chk("R7 R8 long pair", {res_hi_o, res_lo_o}, {exp_hi, exp_lo});
    chk("R9 R4 R6 flag", 64'(ovf_o), 64'(exp_ovf));
  endtask

  task automatic idle_cycle(input bit do_clr);
    valid_i = 1'b0;
    clr = do_clr;
    a = ~a; b = ~b; acc = ~acc; op = 2'd3;
    if (do_clr) exp_ovf = 1'b0;
    @(negedge clk);
    chk("R10 idle valid_o", 64'(valid_o), 64'd0);
    chk("R10 idle hold", 64'(res_o), 64'(exp_res));
    chk("R8 idle hold", {res_hi_o, res_lo_o}, {exp_hi, exp_lo});
    chk("R9 idle flag", 64'(ovf_o), 64'(exp_ovf));
    clr = 1'b0;
  endtask

  logic [15:0] vals [8];
  logic [31:0] accs [4];

  initial begin
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'hffff; vals[3] = 16'h7fff;
    vals[4] = 16'h8000; vals[5] = 16'h1234; vals[6] = 16'hedcb; vals[7] = 16'h4000;
    accs[0] = 32'h0000_0000; accs[1] = 32'h7fff_ffff;
    accs[2] = 32'h8000_0000; accs[3] = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R11
    chk("R11 valid_o", 64'(valid_o), 64'd0);
    chk("R11 res", {res_o, 31'd0, ovf_o}, 64'd0);
    chk("R11 long", {res_hi_o, res_lo_o}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int ia = 0; ia < 8; ia++) begin
      for (int ib = 0; ib < 8; ib++) begin
        for (int o = 0; o < 4; o++) begin
          for (int m = 0; m < 8; m++) begin
            a = {vals[ia], vals[7-ia]};
            b = {vals[ib], vals[(ib+3)%8]};
            acc = accs[(ia + ib + m) % 4];
            acc_hi = accs[(ia + o) % 4];
            acc_lo = ~accs[(ib + m) % 4];
            op = 2'(o);
            sel_a = m[0]; sel_b = m[1]; no_acc = m[2];
            clr = ((ia + ib + o + m) % 5 == 0);
            run_op();
          end
          if (o == 3) idle_cycle((ia + ib) % 3 == 0);
        end
      end
    end
    // R4 R9: overflow together with clear leaves flag set
    valid_i = 1'b1;
    a = 32'h0000_7fff; b = 32'h0000_7fff; acc = 32'h7fff_ffff;
    op = 2'd1; sel_a = 1'b0; sel_b = 1'b0; no_acc = 1'b0; clr = 1'b1;
    run_op();
    chk("R9 set beats clear", 64'(ovf_o), 64'd1);
    clr = 1'b0;
    idle_cycle(1'b1);
    chk("R9 cleared", 64'(ovf_o), 64'd0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule